// File: doc/BRIEF.md
# Text-Mode Character Display Generator

This block turns a running horizontal pixel position into a one-bit video pixel for a text screen of 80 character columns by 40 character rows. Each character cell is 8 pixels wide and 12 lines tall. A video timing source supplies the horizontal position, a strobe at the last pixel of each line, a strobe that starts a new frame, and a blanking flag. The block keeps its own glyph-line and character-row counters.

A character buffer holds one 7-bit code per cell. A font memory holds 12 rows of 8 bits for each of the 128 codes. Both memories have a host write port, so software or a test can fill the screen and load glyphs. At the first pixel of every cell the block reads the cell's code. It then reads the matching glyph row and loads that row into a shift register, which sends out one bit per clock.

The pixel output lags the horizontal position by a fixed three clocks. Blanking is delayed by the same amount, so blanking and pixel data stay aligned at the output.

Top module: `textmode_pixel_gen`

## Requirements
- R1: While `rst_n` is low, and afterwards until new data reaches the output, `pixel` is 0. Reset sets the glyph-line and row counters to zero, so the first line after reset shows glyph line 0 of character row 0.
- R2: The character column is `hcount[10:3]` (hcount divided by 8). The cell read for a pixel is at buffer address row*80 + column, and the host writes 7-bit codes into that same address space through `buf_waddr`.
- R3: The glyph row read for a cell is at font address code*12 + glyph_line, and the host writes 8-bit rows into that same address space through `font_waddr`.
- R4: Bit 7 of a glyph row is shown at the cell's first pixel (hcount multiple of 8) and bit 0 at its last. The pixel for hcount value x appears on `pixel` three clocks after x is presented, when hcount advances by one each clock.
- R5: When `blank` is high for a position, the pixel for that position, three clocks later, is 0.
- R6: `line_end` increments the glyph line. When the glyph line is 11, `line_end` returns it to 0 and increments the character row.
- R7: `frame_end` sets both the glyph line and the character row to zero, and it wins over a simultaneous `line_end`.
- R8: When the host writes a cell in the same clock in which that cell is fetched for display, the display uses the old code. The new code is used at the next fetch of that cell.
- R9: Positions with character column 80 or above, or character row 40 or above, give pixel 0 even when `blank` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hcount | input | 11 | Current horizontal pixel position |
| line_end | input | 1 | High for the last pixel clock of each line |
| frame_end | input | 1 | High for one clock to restart counting at row 0 |
| blank | input | 1 | High outside the visible area |
| buf_we | input | 1 | Character buffer write enable |
| buf_waddr | input | 12 | Character buffer write address (row*80 + column) |
| buf_wdata | input | 7 | Character code to write |
| font_we | input | 1 | Font memory write enable |
| font_waddr | input | 11 | Font write address (code*12 + glyph line) |
| font_wdata | input | 8 | Glyph row bits, bit 7 leftmost |
| pixel | output | 1 | Serialised pixel, three clocks behind hcount |

## Verification
A host write to the character buffer can happen in the same clock in which the display fetches that same cell. In one scanned line, the bench writes a changed code into the fetched cell on every cell-start clock. For that line it expects the glyphs of the old codes. On the following line it expects the glyphs of the new codes. The bench also drives `frame_end` together with `line_end` and expects the counters to restart at row 0.

// File: rtl/txtgen_pkg.sv
// Shared geometry for the text-mode pixel generator.
// Assumes glyph width and height are fixed per build.
package txtgen_pkg;
    localparam int COLS       = 80;
    localparam int ROWS       = 40;
    localparam int GLYPH_W    = 8;
    localparam int GLYPH_H    = 12;
    localparam int CODES      = 128;
    localparam int HCNT_W     = 11;
    localparam int PIPE_LAT   = 3;

    localparam int CELLS      = COLS * ROWS;
    localparam int BUF_AW     = $clog2(CELLS);
    localparam int CODE_W     = $clog2(CODES);
    localparam int FONT_DEPTH = CODES * GLYPH_H;
    localparam int FONT_AW    = $clog2(FONT_DEPTH);
    localparam int GLINE_W    = $clog2(GLYPH_H);
    localparam int ROW_W      = $clog2(ROWS) + 1;
    localparam int XSUB_W     = $clog2(GLYPH_W);
    localparam int COL_W      = HCNT_W - XSUB_W;
endpackage

// File: rtl/txt_sync_ram.sv
// Simple dual-port synchronous RAM: one write port, one registered read port.
// Assumes read-first behaviour on same-address collision (old data returned).
// Reads outside DEPTH return zero; writes outside DEPTH are dropped.
module txt_sync_ram #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write port and registered read port, read sees pre-write contents
    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
        rdata <= (int'(raddr) < DEPTH) ? mem[raddr] : '0;
    end
endmodule

// File: rtl/txt_line_ctr.sv
// Glyph-line and character-row counters for the text display.
// Assumes line_end pulses once per line and frame_end once per frame.
module txt_line_ctr
    import txtgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_end,
    input  logic               frame_end,
    output logic [GLINE_W-1:0] gline,
    output logic [ROW_W-1:0]   crow
);
    localparam logic [GLINE_W-1:0] GLINE_LAST = GLINE_W'(GLYPH_H - 1);

    // Advance glyph line per line, character row per glyph wrap
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            gline <= '0;
            crow  <= '0;
        end else if (line_end) begin
            if (gline == GLINE_LAST) begin
                gline <= '0;
                crow  <= crow + 1'b1;
            end else begin
                gline <= gline + 1'b1;
            end
        end
    end

    p_gline_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(gline) < GLYPH_H);

    p_gline_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !frame_end && gline == GLINE_LAST)
        |=> (gline == '0 && crow == ROW_W'($past(crow) + 1'b1)));

    p_frame_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (gline == '0 && crow == '0));
endmodule

// File: rtl/txt_glyph_shift.sv
// Glyph row serialiser: loads a row on load, shifts MSB first otherwise.
// Assumes load arrives once per cell; cell_ok marks on-screen cells.
module txt_glyph_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         load_ok,
    input  logic [W-1:0] din,
    output logic         pix_bit
);
    logic [W-1:0] sh_q;
    logic         ok_q;

    // Load a new glyph row or shift the current one left
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            ok_q <= 1'b0;
        end else if (load) begin
            sh_q <= din;
            ok_q <= load_ok;
        end else begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign pix_bit = sh_q[W-1] & ok_q;
endmodule

// File: rtl/textmode_pixel_gen.sv
// Text-mode pixel generator: 80x40 cells of 8x12 glyphs, one bit per clock.
// Assumes hcount advances by one per clock through each visible line and
// cells start at hcount multiples of GLYPH_W. Output lags hcount by PIPE_LAT.
module textmode_pixel_gen
    import txtgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HCNT_W-1:0]  hcount,
    input  logic               line_end,
    input  logic               frame_end,
    input  logic               blank,
    input  logic               buf_we,
    input  logic [BUF_AW-1:0]  buf_waddr,
    input  logic [CODE_W-1:0]  buf_wdata,
    input  logic               font_we,
    input  logic [FONT_AW-1:0] font_waddr,
    input  logic [GLYPH_W-1:0] font_wdata,
    output logic               pixel
);
    logic [GLINE_W-1:0] gline;
    logic [ROW_W-1:0]   crow;

    txt_line_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_end  (line_end),
        .frame_end (frame_end),
        .gline     (gline),
        .crow      (crow)
    );

    // Stage 0: cell detection and character buffer address
    logic [COL_W-1:0]  col;
    logic              cell_start;
    logic              cell_ok;
    logic [BUF_AW-1:0] buf_raddr;

    assign col        = hcount[HCNT_W-1:XSUB_W];
    assign cell_start = (hcount[XSUB_W-1:0] == '0);
    assign cell_ok    = (int'(col) < COLS) && (int'(crow) < ROWS);

    // Row-major cell address, parked at zero for off-screen cells
    always_comb begin
        buf_raddr = '0;
        if (cell_ok) begin
            buf_raddr = BUF_AW'(crow) * BUF_AW'(COLS) + BUF_AW'(col);
        end
    end

    logic [CODE_W-1:0] code_q;

    txt_sync_ram #(.DEPTH(CELLS), .DW(CODE_W), .AW(BUF_AW)) u_chars (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (buf_raddr),
        .rdata (code_q)
    );

    // Stage 1/2 control: carry load strobe, on-screen flag and glyph line
    logic               ld_s1, ok_s1, ld_s2, ok_s2;
    logic [GLINE_W-1:0] gline_s1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_s1    <= 1'b0;
            ok_s1    <= 1'b0;
            gline_s1 <= '0;
            ld_s2    <= 1'b0;
            ok_s2    <= 1'b0;
        end else begin
            ld_s1    <= cell_start;
            ok_s1    <= cell_ok;
            gline_s1 <= gline;
            ld_s2    <= ld_s1;
            ok_s2    <= ok_s1;
        end
    end

    logic [FONT_AW-1:0] font_raddr;
    logic [GLYPH_W-1:0] glyph_row;

    assign font_raddr = FONT_AW'(code_q) * FONT_AW'(GLYPH_H) + FONT_AW'(gline_s1);

    txt_sync_ram #(.DEPTH(FONT_DEPTH), .DW(GLYPH_W), .AW(FONT_AW)) u_font (
        .clk   (clk),
        .we    (font_we),
        .waddr (font_waddr),
        .wdata (font_wdata),
        .raddr (font_raddr),
        .rdata (glyph_row)
    );

    logic shift_bit;

    txt_glyph_shift #(.W(GLYPH_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_s2),
        .load_ok (ok_s2),
        .din     (glyph_row),
        .pix_bit (shift_bit)
    );

    // Blank delay line matching the fetch pipeline depth
    logic [PIPE_LAT-1:0] blank_dl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_dl <= '1;
        end else begin
            blank_dl[0] <= blank;
            for (int i = 1; i < PIPE_LAT; i++) begin
                blank_dl[i] <= blank_dl[i-1];
            end
        end
    end

    assign pixel = shift_bit & ~blank_dl[PIPE_LAT-1];

    p_blank_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(blank, 3) |-> !pixel);

    p_offscreen_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s2 && !ok_s2) |=> !pixel);

    p_cell_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cell_ok |-> (int'(buf_raddr) < CELLS));

    p_font_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_s1 |-> (int'(gline_s1) < GLYPH_H));
endmodule

// File: tb/textmode_pixel_gen_tb.sv
// Self-checking bench: random font and screen contents, scanned lines with
// random blanking and host writes, plus directed corner cases.
module textmode_pixel_gen_tb;
    import txtgen_pkg::*;

    localparam int H_TOT  = 648;
    localparam int H_IDLE = 700;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [HCNT_W-1:0]  hcount = '0;
    logic               line_end = 1'b0, frame_end = 1'b0, blank = 1'b1;
    logic               buf_we = 1'b0, font_we = 1'b0;
    logic [BUF_AW-1:0]  buf_waddr = '0;
    logic [CODE_W-1:0]  buf_wdata = '0;
    logic [FONT_AW-1:0] font_waddr = '0;
    logic [GLYPH_W-1:0] font_wdata = '0;
    logic               pixel;

    always #5 clk = ~clk;

    textmode_pixel_gen u_dut (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .line_end(line_end),
        .frame_end(frame_end), .blank(blank), .buf_we(buf_we),
        .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .font_we(font_we),
        .font_waddr(font_waddr), .font_wdata(font_wdata), .pixel(pixel)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int cm [CELLS];
    int fm [FONT_DEPTH];
    int m_gline = 0, m_row = 0;
    bit pv [3];
    int pe [3];
    string pt [3];
    bit c_ok = 0;
    int c_code = 0, c_gline = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: pixel actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int glyph_bit(input int code, input int gl, input int k);
        return (fm[code * GLYPH_H + gl] >> (GLYPH_W - 1 - k)) & 1;
    endfunction

    // One clock: check output of three clocks ago, then drive and update model
    task automatic cyc(input int h, input bit le, input bit fe, input bit bl,
                       input bit bwe, input int bwa, input int bwd,
                       input bit fwe, input int fwa, input int fwd, input string tg);
        int col, k, e;
        string t;
        @(negedge clk);
        if (pv[2]) check(int'(pixel) == pe[2], pt[2], int'(pixel), pe[2]);
        col = h / GLYPH_W;
        k   = h % GLYPH_W;
        if (k == 0) begin
            c_ok    = (col < COLS) && (m_row < ROWS);
            c_code  = c_ok ? cm[m_row * COLS + col] : 0;
            c_gline = m_gline;
        end
        if (bl) begin e = 0; t = "R5"; end
        else if (!c_ok) begin e = 0; t = "R9"; end
        else begin e = glyph_bit(c_code, c_gline, k); t = tg; end
        pv[2] = pv[1]; pe[2] = pe[1]; pt[2] = pt[1];
        pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
        pv[0] = 1'b1;  pe[0] = e;     pt[0] = t;
        hcount = HCNT_W'(h); line_end = le; frame_end = fe; blank = bl;
        buf_we = bwe; buf_waddr = BUF_AW'(bwa); buf_wdata = CODE_W'(bwd);
        font_we = fwe; font_waddr = FONT_AW'(fwa); font_wdata = GLYPH_W'(fwd);
        if (bwe) cm[bwa] = bwd;
        if (fwe) fm[fwa] = fwd;
        if (fe) begin
            m_gline = 0; m_row = 0;
        end else if (le) begin
            if (m_gline == GLYPH_H - 1) begin m_gline = 0; m_row++; end
            else m_gline++;
        end
    endtask

    task automatic scan_line(input string tg, input bit rblank, input bit rwr,
                             input bit collide, input bit open_tail);
        for (int h = 0; h < H_TOT; h++) begin
            bit bl, we;
            int wa, wd, col;
            col = h / GLYPH_W;
            bl = (h >= COLS * GLYPH_W) ? !open_tail : (rblank && ($urandom % 8 == 0));
            we = 1'b0; wa = 0; wd = 0;
            if (collide && (h % GLYPH_W == 0) && col < COLS && m_row < ROWS) begin
                we = 1'b1; wa = m_row * COLS + col; wd = (cm[wa] + 1) % CODES;
            end else if (rwr && ($urandom % 16 == 0)) begin
                we = 1'b1; wa = $urandom % CELLS; wd = $urandom % CODES;
            end
            cyc(h, h == H_TOT - 1, 1'b0, bl, we, wa, wd, 1'b0, 0, 0, tg);
        end
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) cyc(H_IDLE, 1'b1, 1'b0, 1'b1, 0, 0, 0, 0, 0, 0, "R6");
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1: watchdog actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5EED));
        pv = '{default: 1'b0};
        // R1: output held low during reset
        repeat (4) begin
            @(negedge clk);
            check(pixel == 1'b0, "R1", int'(pixel), 0);
        end
        rst_n = 1'b1;
        // R3: load the font, R2: fill the screen (blanked, no line strobes)
        for (int i = 0; i < FONT_DEPTH; i++)
            cyc(H_IDLE, 0, 0, 1, 0, 0, 0, 1, i, $urandom % 256, "R3");
        for (int i = 0; i < CELLS; i++)
            cyc(H_IDLE, 0, 0, 1, 1, i, $urandom % CODES, 0, 0, 0, "R2");
        // R1: first line after reset is row 0, glyph line 0
        scan_line("R1", 0, 0, 0, 0);
        for (int l = 0; l < 5; l++) scan_line("R4", 1, 1, 0, 0);
        for (int l = 0; l < 5; l++) scan_line("R3", 0, 1, 0, 0);
        // R6: lines around the glyph-line wrap into row 1
        for (int l = 0; l < 3; l++) scan_line("R6", 1, 1, 0, 0);
        advance(27);
        scan_line("R2", 0, 1, 0, 0);
        // R8: write and fetch of the same cell in one clock, then reuse
        scan_line("R8", 0, 0, 1, 0);
        scan_line("R8", 0, 0, 0, 0);
        // R9: columns past the screen edge left unblanked
        scan_line("R9", 0, 0, 0, 1);
        advance(ROWS * GLYPH_H - (m_row * GLYPH_H + m_gline));
        // R9: first row below the screen, unblanked
        scan_line("R9", 0, 0, 0, 1);
        // R7: frame_end together with line_end restarts at row 0
        cyc(H_IDLE, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R7");
        scan_line("R7", 0, 0, 0, 0);
        advance(5);
        cyc(H_IDLE, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R7");
        scan_line("R7", 1, 1, 0, 0);
        for (int l = 0; l < 4; l++) scan_line("R4", 1, 1, 0, 0);
        repeat (4) cyc(H_IDLE, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R5");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule